// File: doc/BRIEF.md
# External Asynchronous Bus Cycle Sequencer

This block turns single host requests into timed read and write cycles on an external asynchronous memory bus that is divided into eight chip-select spaces. It runs on a clock at twice the bus rate, so one clock period is one half bus cycle (a "tick"). Every access goes through four phases: an optional idle gap with all selects high, a setup phase with address and select driven, a strobe phase with the read or write strobe low, and a hold phase with the strobe released but the select still low.

Each space has two configuration words. The gap word holds five 3-bit idle codes, one for each kind of access pairing. The timing word holds the read wait, write wait, setup and hold codes. The block remembers the kind and space of the last access. It measures the required gap from the end of that access's hold phase, so time the host already spent idle counts toward the gap. The host pulses `start` and waits for a one-cycle `ready`. For reads, `rdata` is valid in the `ready` cycle.

Top module: `ext_bus_sequencer`

## Requirements
- R1: While reset is asserted, and whenever no access is in progress, all `bus_cs_n` bits, `bus_rd_n` and `bus_we_n` are high, and `busy`, `ready` and `bus_doe` are low.
- R2: The setup phase lasts 2*S+1 ticks, where S is timing-word bits [8:7]. During setup, the addressed space's select is low, both strobes are high and `bus_addr` carries the request address.
- R3: A read strobe lasts 2*(W+1) ticks. W is decoded from timing-word bits [3:0]: codes 0 to 6 give 0 to 6, 7 gives 8, 8 gives 10, 9 gives 12, 10 gives 14, 11 gives 18, and 12 to 15 give 24.
- R4: A write strobe lasts 2*(W+1) ticks, where W comes from timing-word bits [6:4]. Code 0 reuses the read wait decode, and code k from 1 to 7 gives k-1. `bus_doe` is high and `bus_dout` holds the write data from setup through hold.
- R5: The hold phase lasts 2*H+1 ticks, where H is timing-word bits [10:9]. The select stays low and both strobes stay high during hold.
- R6: `ready` is high for exactly one tick, the last hold tick, and `busy` is low on the next tick. For a read, `rdata` in that tick equals `bus_din` as sampled at the end of the last strobe tick.
- R7: An idle code decodes to a number of bus cycles: codes 0, 1 and 2 give 0, 1 and 2, and codes 3 to 7 give 4, 6, 8, 10 and 12. The gap in ticks is twice that number.
- R8: The idle code is taken from the gap word of the previous access's space. After a write it is bits [2:0]. After a read it is bits [5:3] for a write to a different space, [8:6] for a write to the same space, [11:9] for a read from a different space, and [14:12] for a read from the same space.
- R9: The number of ticks with all selects high, between the last hold tick of one access and the first setup tick of the next, is the larger of the R7/R8 gap and the number of idle ticks the host left, including the `start` tick. The first access after reset has no gap.
- R10: A `start` pulse while `busy` is high is ignored and leaves the ongoing access unchanged.
- R11: The reset value of every gap field is code 2, and setup, hold and write-wait codes are 0. The read-wait code is 3 in every space except space 1, whose reset read-wait code is 2.
- R12: At most one select is low at any time, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-tick request pulse |
| req_space | input | 3 | Target chip-select space |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| ready | output | 1 | Completion pulse on the last hold tick |
| rdata | output | 16 | Captured read data |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_space | input | 3 | Space whose word is written |
| cfg_sel_wait | input | 1 | 1 = timing word, 0 = gap word |
| cfg_wdata | input | 15 | Configuration word value |
| bus_addr | output | 24 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | External data output enable |
| bus_din | input | 16 | External read data |
| bus_cs_n | output | 8 | Active-low chip selects, one per space |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |

## Verification
Back-to-back reads across two spaces, followed by a write to the same space, exercise the reset timing words and separate the different-space and same-space gap fields. A configured space is then driven with read-read, read-write, write-read and cross-space sequences with a distinct code in each gap field. A mix-up between any two pairings then shows as a wrong count of ticks with all selects high. A long host pause before one access shows whether idle time is credited against the gap. Loops over all eight idle codes, all read-wait codes from 8 up to the saturated ones, and all write-wait codes separate each decode entry. A changing `bus_din` pattern pins down the exact tick at which read data is captured.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

  // Tick counter width: longest phase is a 24-cycle strobe plus one, doubled.
  localparam int TICK_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // Gap word: one idle code per access pairing.
  typedef struct packed {
    logic [2:0] rd_rd_same;
    logic [2:0] rd_rd_other;
    logic [2:0] rd_wr_same;
    logic [2:0] rd_wr_other;
    logic [2:0] after_wr;
  } gap_cfg_t;

  // Timing word: hold, setup, write wait, read wait.
  typedef struct packed {
    logic [1:0] hold;
    logic [1:0] setup;
    logic [2:0] wr_wait;
    logic [3:0] rd_wait;
  } wait_cfg_t;

  localparam int CFG_W = $bits(gap_cfg_t);

  function automatic logic [4:0] rd_wait_cycles(input logic [3:0] code);
    logic [4:0] cyc;
    if (code <= 4'd6) cyc = {1'b0, code};
    else begin
      unique case (code)
        4'd7:    cyc = 5'd8;
        4'd8:    cyc = 5'd10;
        4'd9:    cyc = 5'd12;
        4'd10:   cyc = 5'd14;
        4'd11:   cyc = 5'd18;
        default: cyc = 5'd24;
      endcase
    end
    return cyc;
  endfunction

  function automatic logic [4:0] wr_wait_cycles(input logic [2:0] code,
                                                input logic [3:0] rd_code);
    return (code == 3'd0) ? rd_wait_cycles(rd_code) : {2'b00, code - 3'd1};
  endfunction

  function automatic logic [4:0] idle_cycles(input logic [2:0] code);
    return (code <= 3'd2) ? {2'b00, code} : {1'b0, code - 3'd1, 1'b0};
  endfunction

endpackage

// File: rtl/ext_bus_seq_regs.sv
module ext_bus_seq_regs
  import ext_bus_seq_pkg::*;
#(
  parameter int NSPACE      = 8,
  parameter int SPW         = 3,
  parameter int ALT_SPACE   = 1,
  parameter int RD_DFLT     = 3,
  parameter int RD_DFLT_ALT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SPW-1:0]   cfg_space,
  input  logic             cfg_sel_wait,
  input  logic [CFG_W-1:0] cfg_wdata,
  output gap_cfg_t         gap_q  [NSPACE],
  output wait_cfg_t        wait_q [NSPACE]
);

  localparam gap_cfg_t GAP_RST = '{default: 3'd2};

  for (genvar i = 0; i < NSPACE; i++) begin : g_space
    localparam logic [3:0] RD_RST = (i == ALT_SPACE) ? 4'(RD_DFLT_ALT) : 4'(RD_DFLT);
    logic hit;
    logic gap_en;
    logic wait_en;

    always_comb begin
      hit     = cfg_we && (cfg_space == SPW'(i));
      gap_en  = hit && !cfg_sel_wait;
      wait_en = hit && cfg_sel_wait;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q[i]  <= GAP_RST;
        wait_q[i] <= '{hold: 2'd0, setup: 2'd0, wr_wait: 3'd0, rd_wait: RD_RST};
      end else begin
        if (gap_en)  gap_q[i]  <= gap_cfg_t'(cfg_wdata);
        if (wait_en) wait_q[i] <= wait_cfg_t'(cfg_wdata[$bits(wait_cfg_t)-1:0]);
      end
    end
  end

endmodule

// File: rtl/ext_bus_seq_gap.sv
module ext_bus_seq_gap
  import ext_bus_seq_pkg::*;
#(
  parameter int NSPACE = 8,
  parameter int SPW    = 3,
  parameter int TW     = TICK_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_idle,
  input  logic           accept,
  input  logic           done,
  input  logic           req_wr,
  input  logic [SPW-1:0] req_space,
  input  gap_cfg_t       gap_q [NSPACE],
  output logic [TW-1:0]  gap_rem
);

  localparam logic [TW-1:0] CNT_SAT = {TW{1'b1}} - TW'(1);

  logic           prev_vld_q, prev_vld_d;
  logic           prev_wr_q,  prev_wr_d;
  logic [SPW-1:0] prev_sp_q,  prev_sp_d;
  logic [TW-1:0]  idle_cnt_q, idle_cnt_d;

  gap_cfg_t      sel;
  logic [2:0]    code;
  logic          same;
  logic [TW-1:0] need;
  logic [TW-1:0] elapsed;

  // Pairing decode against the previous access (R8) and gap size (R7, R9).
  always_comb begin
    sel  = gap_q[prev_sp_q];
    same = (prev_sp_q == req_space);
    if (prev_wr_q)   code = sel.after_wr;
    else if (req_wr) code = same ? sel.rd_wr_same : sel.rd_wr_other;
    else             code = same ? sel.rd_rd_same : sel.rd_rd_other;
    need    = prev_vld_q ? TW'({idle_cycles(code), 1'b0}) : '0;
    elapsed = idle_cnt_q + TW'(1);
    gap_rem = (need > elapsed) ? (need - elapsed) : '0;
  end

  always_comb begin
    prev_vld_d = prev_vld_q;
    prev_wr_d  = prev_wr_q;
    prev_sp_d  = prev_sp_q;
    if (accept) begin
      prev_vld_d = 1'b1;
      prev_wr_d  = req_wr;
      prev_sp_d  = req_space;
    end
    if (done)
      idle_cnt_d = '0;
    else if (in_idle && !accept && idle_cnt_q != CNT_SAT)
      idle_cnt_d = idle_cnt_q + TW'(1);
    else
      idle_cnt_d = idle_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld_q <= 1'b0;
      prev_wr_q  <= 1'b0;
      prev_sp_q  <= '0;
      idle_cnt_q <= '0;
    end else begin
      prev_vld_q <= prev_vld_d;
      prev_wr_q  <= prev_wr_d;
      prev_sp_q  <= prev_sp_d;
      idle_cnt_q <= idle_cnt_d;
    end
  end

  // R9
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (gap_rem <= TW'(24)));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idle_cnt_q == '0));

endmodule

// File: rtl/ext_bus_seq_fsm.sv
module ext_bus_seq_fsm
  import ext_bus_seq_pkg::*;
#(
  parameter int NSPACE = 8,
  parameter int SPW    = 3,
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int TW     = TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SPW-1:0]    req_space,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  wait_cfg_t         wait_q [NSPACE],
  input  logic [TW-1:0]     gap_rem,
  input  logic [DW-1:0]     bus_din,
  output logic              accept,
  output logic              done,
  output logic              in_idle,
  output logic [DW-1:0]     rdata,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  output logic [NSPACE-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n
);

  phase_e         phase_q, phase_d;
  logic [TW-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  rdata_q;
  logic [SPW-1:0] space_q;
  logic           wr_q;
  logic [TW-1:0]  su_q, stb_q, ho_q;

  wait_cfg_t      wc;
  logic [4:0]     acc_cyc;
  logic [TW-1:0]  su_n, stb_n, ho_n;
  logic           last;
  logic           cap_rd;
  logic           active;

  // Per-request tick counts from the target space's timing word (R2 to R5).
  always_comb begin
    wc      = wait_q[req_space];
    acc_cyc = req_wr ? wr_wait_cycles(wc.wr_wait, wc.rd_wait) : rd_wait_cycles(wc.rd_wait);
    su_n    = TW'({wc.setup, 1'b1});
    stb_n   = TW'({acc_cyc + 5'd1, 1'b0});
    ho_n    = TW'({wc.hold, 1'b1});
  end

  always_comb begin
    in_idle = (phase_q == PH_IDLE);
    accept  = in_idle && start;
    last    = (cnt_q == '0);
    done    = (phase_q == PH_HOLD) && last;
    cap_rd  = (phase_q == PH_STROBE) && last && !wr_q;
    active  = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  end

  // Next-state: phase walk with a down-counter per phase.
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (gap_rem != '0) begin
            phase_d = PH_GAP;
            cnt_d   = gap_rem - TW'(1);
          end else begin
            phase_d = PH_SETUP;
            cnt_d   = su_n - TW'(1);
          end
        end
      end
      PH_GAP: begin
        if (last) begin
          phase_d = PH_SETUP;
          cnt_d   = su_q - TW'(1);
        end else cnt_d = cnt_q - TW'(1);
      end
      PH_SETUP: begin
        if (last) begin
          phase_d = PH_STROBE;
          cnt_d   = stb_q - TW'(1);
        end else cnt_d = cnt_q - TW'(1);
      end
      PH_STROBE: begin
        if (last) begin
          phase_d = PH_HOLD;
          cnt_d   = ho_q - TW'(1);
        end else cnt_d = cnt_q - TW'(1);
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else cnt_d = cnt_q - TW'(1);
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // Request capture, enabled only by an accepted start (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      space_q <= '0;
      wr_q    <= 1'b0;
      su_q    <= '0;
      stb_q   <= '0;
      ho_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      space_q <= req_space;
      wr_q    <= req_wr;
      su_q    <= su_n;
      stb_q   <= stb_n;
      ho_q    <= ho_n;
    end
  end

  // Read data capture on the last strobe tick (R6).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= bus_din;
  end

  always_comb begin
    rdata    = rdata_q;
    bus_addr = addr_q;
    bus_dout = wdata_q;
    bus_doe  = active && wr_q;
    bus_cs_n = active ? ~(NSPACE'(1) << space_q) : '1;
    bus_rd_n = !((phase_q == PH_STROBE) && !wr_q);
    bus_we_n = !((phase_q == PH_STROBE) && wr_q);
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_we_n));

  // R12
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R2
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|(~bus_cs_n)) |-> (bus_rd_n && bus_we_n));

  // R5
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_we_n)) |-> ($countones(~bus_cs_n) == 1));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_idle && !done));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && start) |=> ($stable(bus_addr) && $stable(bus_dout)));

endmodule

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer
  import ext_bus_seq_pkg::*;
#(
  parameter int NSPACE = 8,
  parameter int AW     = 24,
  parameter int DW     = 16,
  localparam int SPW   = $clog2(NSPACE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SPW-1:0]    req_space,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              ready,
  output logic [DW-1:0]     rdata,
  input  logic              cfg_we,
  input  logic [SPW-1:0]    cfg_space,
  input  logic              cfg_sel_wait,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  output logic [NSPACE-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n
);

  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  gap_cfg_t         gap_q  [NSPACE];
  wait_cfg_t        wait_q [NSPACE];
  logic [TICK_W-1:0] gap_rem;
  logic             accept;
  logic             done;
  logic             in_idle;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  ext_bus_seq_regs #(.NSPACE(NSPACE), .SPW(SPW)) u_regs (
    .clk, .rst_n(rst_s_n), .cfg_we, .cfg_space, .cfg_sel_wait, .cfg_wdata,
    .gap_q, .wait_q
  );

  ext_bus_seq_gap #(.NSPACE(NSPACE), .SPW(SPW), .TW(TICK_W)) u_gap (
    .clk, .rst_n(rst_s_n), .in_idle, .accept, .done, .req_wr, .req_space,
    .gap_q, .gap_rem
  );

  ext_bus_seq_fsm #(.NSPACE(NSPACE), .SPW(SPW), .AW(AW), .DW(DW), .TW(TICK_W)) u_fsm (
    .clk, .rst_n(rst_s_n), .start, .req_space, .req_wr, .req_addr, .req_wdata,
    .wait_q, .gap_rem, .bus_din, .accept, .done, .in_idle, .rdata,
    .bus_addr, .bus_dout, .bus_doe, .bus_cs_n, .bus_rd_n, .bus_we_n
  );

  assign busy  = !in_idle;
  assign ready = done;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> (bus_cs_n == '1 && bus_rd_n && bus_we_n && !bus_doe));

endmodule

// File: tb/ext_bus_sequencer_tb_top.sv
module ext_bus_sequencer_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  req_space;
  logic        req_wr;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        busy, ready;
  logic [15:0] rdata;
  logic        cfg_we;
  logic [2:0]  cfg_space;
  logic        cfg_sel_wait;
  logic [14:0] cfg_wdata;
  logic [23:0] bus_addr;
  logic [15:0] bus_dout;
  logic        bus_doe;
  logic [15:0] bus_din;
  logic [7:0]  bus_cs_n;
  logic        bus_rd_n, bus_we_n;

  always #(CLK_P/2) clk = ~clk;

  ext_bus_sequencer dut_i (
    .clk, .rst_n, .start, .req_space, .req_wr, .req_addr, .req_wdata,
    .busy, .ready, .rdata, .cfg_we, .cfg_space, .cfg_sel_wait, .cfg_wdata,
    .bus_addr, .bus_dout, .bus_doe, .bus_din, .bus_cs_n, .bus_rd_n, .bus_we_n
  );

  typedef struct {
    logic [7:0]  cs_n;
    logic        rd_n, we_n, rdy, bsy, doe, chk_rd;
    logic [23:0] addr;
    logic [15:0] dout, rd;
    int          tag;
  } exp_t;

  exp_t eq[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   off_cnt = 0;
  bit   finished = 0;

  // Behavioural model state.
  int m_gap[8][5];           // 0 after write, 1 rd-wr other, 2 rd-wr same, 3 rd-rd other, 4 rd-rd same
  int m_rdc[8], m_wrc[8], m_su[8], m_ho[8];
  bit p_vld = 0;
  bit p_wr  = 0;
  int p_sp  = 0;

  function automatic int rd_cyc(int c);
    int t[16] = '{0, 1, 2, 3, 4, 5, 6, 8, 10, 12, 14, 18, 24, 24, 24, 24};
    return t[c];
  endfunction

  function automatic int wr_cyc(int c, int rc);
    if (c == 0) return rd_cyc(rc);
    return c - 1;
  endfunction

  function automatic int idle_cyc(int c);
    int t[8] = '{0, 1, 2, 4, 6, 8, 10, 12};
    return t[c];
  endfunction

  function automatic logic [15:0] din_at(int c);
    return 16'((c * 40503) ^ 16'h5A5A);
  endfunction

  function automatic string tname(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      9: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(bit ok, int tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d act=%0h exp=%0h", tname(tag), what, cyc, act, exp);
    end
  endtask

  function automatic exp_t idle_e();
    exp_t e;
    e.cs_n = 8'hFF; e.rd_n = 1; e.we_n = 1; e.rdy = 0; e.bsy = 0; e.doe = 0;
    e.chk_rd = 0; e.addr = '0; e.dout = '0; e.rd = '0; e.tag = 1;
    return e;
  endfunction

  // One tick: compare this cycle's outputs to the model, then drive bus_din.
  task automatic tick();
    exp_t e;
    @(negedge clk);
    cyc++;
    e = (eq.size() > 0) ? eq.pop_front() : idle_e();
    chk(bus_cs_n === e.cs_n, e.tag, "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
    chk(bus_rd_n === e.rd_n, e.tag, "rd_n", 32'(bus_rd_n), 32'(e.rd_n));
    chk(bus_we_n === e.we_n, e.tag, "we_n", 32'(bus_we_n), 32'(e.we_n));
    chk(ready === e.rdy, 6, "ready", 32'(ready), 32'(e.rdy));
    chk(busy === e.bsy, e.tag, "busy", 32'(busy), 32'(e.bsy));
    chk(bus_doe === e.doe, 4, "doe", 32'(bus_doe), 32'(e.doe));
    // R12: at most one select low
    chk($countones(~bus_cs_n) <= 1, 12, "cs count", 32'(bus_cs_n), 32'(e.cs_n));
    if (e.cs_n != 8'hFF) chk(bus_addr === e.addr, 2, "addr", 32'(bus_addr), 32'(e.addr));
    if (e.doe) chk(bus_dout === e.dout, 4, "dout", 32'(bus_dout), 32'(e.dout));
    if (e.chk_rd) chk(rdata === e.rd, 6, "rdata", 32'(rdata), 32'(e.rd));
    if (e.rdy) off_cnt = 0;
    else if (!e.bsy) off_cnt++;
    bus_din = din_at(cyc);
  endtask

  task automatic wait_idle();
    while (eq.size() > 0 || off_cnt == 0) tick();
  endtask

  task automatic set_gap(int sp, int aw, int rwo, int rws, int rro, int rrs);
    wait_idle();
    cfg_we = 1; cfg_space = 3'(sp); cfg_sel_wait = 0;
    cfg_wdata = 15'(aw | (rwo << 3) | (rws << 6) | (rro << 9) | (rrs << 12));
    m_gap[sp] = '{aw, rwo, rws, rro, rrs};
    tick();
    cfg_we = 0;
  endtask

  task automatic set_wait(int sp, int rc, int wc, int su, int ho);
    wait_idle();
    cfg_we = 1; cfg_space = 3'(sp); cfg_sel_wait = 1;
    cfg_wdata = 15'(rc | (wc << 4) | (su << 7) | (ho << 9));
    m_rdc[sp] = rc; m_wrc[sp] = wc; m_su[sp] = su; m_ho[sp] = ho;
    tick();
    cfg_we = 0;
  endtask

  // Issue an access and queue the expected per-tick bus picture.
  task automatic access(int sp, bit wr, logic [23:0] a, logic [15:0] d);
    int g, rem, su, stb, ho, code, n, last_stb;
    exp_t e;
    wait_idle();
    if (!p_vld) g = 0;
    else begin
      if (p_wr) code = m_gap[p_sp][0];
      else if (wr) code = (p_sp == sp) ? m_gap[p_sp][2] : m_gap[p_sp][1];
      else code = (p_sp == sp) ? m_gap[p_sp][4] : m_gap[p_sp][3];
      g = 2 * idle_cyc(code);
    end
    rem = (g > off_cnt) ? g - off_cnt : 0;
    su  = 2 * m_su[sp] + 1;
    stb = 2 * ((wr ? wr_cyc(m_wrc[sp], m_rdc[sp]) : rd_cyc(m_rdc[sp])) + 1);
    ho  = 2 * m_ho[sp] + 1;
    n   = cyc + 1;
    last_stb = n + rem + su + stb - 1;
    for (int i = 0; i < rem; i++) begin
      e = idle_e(); e.bsy = 1; e.tag = 9; eq.push_back(e);
    end
    for (int i = 0; i < su + stb + ho; i++) begin
      e = idle_e(); e.bsy = 1; e.cs_n = ~(8'(1) << sp); e.addr = a; e.dout = d; e.doe = wr;
      if (i < su) e.tag = 2;
      else if (i < su + stb) begin
        e.tag = wr ? 4 : 3;
        if (wr) e.we_n = 0; else e.rd_n = 0;
      end else begin
        e.tag = 5;
        if (i == su + stb + ho - 1) begin
          e.rdy = 1; e.tag = 6; e.chk_rd = !wr; e.rd = din_at(last_stb);
        end
      end
      eq.push_back(e);
    end
    start = 1; req_space = 3'(sp); req_wr = wr; req_addr = a; req_wdata = d;
    tick();
    start = 0;
    p_vld = 1; p_wr = wr; p_sp = sp;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; req_space = 0; req_wr = 0; req_addr = 0; req_wdata = 0;
    cfg_we = 0; cfg_space = 0; cfg_sel_wait = 0; cfg_wdata = 0; bus_din = 0;
    // R11: model starts from the documented reset words
    for (int s = 0; s < 8; s++) begin
      m_gap[s] = '{2, 2, 2, 2, 2};
      m_rdc[s] = (s == 1) ? 2 : 3; m_wrc[s] = 0; m_su[s] = 0; m_ho[s] = 0;
    end
    // R1: reset state
    repeat (4) tick();
    rst_n = 1;
    repeat (4) tick();

    // R11 defaults, R9 first access has no gap, R3 read strobe
    access(0, 0, 24'h000100, 16'h0);
    // R8 read then read other space; R11 space 1 read wait
    access(1, 0, 24'h000200, 16'h0);
    // R4 write wait code 0 reuses read wait; R8 read then write same space
    access(1, 1, 24'h000204, 16'hBEEF);

    // R7 R8 distinct code per pairing; R2 R5 long setup and hold
    set_gap(3, 7, 3, 4, 5, 6);
    set_wait(3, 11, 5, 3, 2);
    access(3, 0, 24'h030000, 16'h0);
    access(3, 0, 24'h030004, 16'h0);   // read-read same
    access(3, 1, 24'h030008, 16'h1234); // read-write same
    access(3, 0, 24'h03000C, 16'h0);   // after write
    access(5, 0, 24'h050000, 16'h0);   // read-read other (space 3 word)
    access(3, 1, 24'h030010, 16'h4321); // read-write other (space 5 word)

    // R9: long host pause already covers the gap
    wait_idle();
    repeat (40) tick();
    access(3, 0, 24'h030020, 16'h0);

    // R7 every idle code; R3 read wait codes 8..15; R2 R5 varied codes
    for (int k = 0; k < 8; k++) begin
      set_gap(2, k, 1, 1, 1, 1);
      set_wait(2, 8 + k, 0, k % 4, (k + 1) % 4);
      access(2, 1, 24'h020000 + 24'(k), 16'(16'hA000 + k));
      access(2, 1, 24'h020100 + 24'(k), 16'(16'hB000 + k));
      access(2, 0, 24'h020200 + 24'(k), 16'h0);
    end

    // R4 every write wait code
    for (int w = 1; w < 8; w++) begin
      set_wait(4, 5, w, 0, 0);
      access(4, 1, 24'h040000 + 24'(w), 16'(16'hC000 + w));
    end

    // R10: start pulses while busy are ignored
    access(6, 0, 24'h060000, 16'h0);
    repeat (2) tick();
    start = 1; req_space = 7; req_wr = 1; req_addr = 24'hFFFFFF; req_wdata = 16'hDEAD;
    tick();
    start = 0;
    repeat (3) tick();
    start = 1;
    tick();
    start = 0;
    wait_idle();
    repeat (5) tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule